// File: doc/BRIEF.md
# Two-Level Trim Dither Modulator

This block drives a 4-bit oscillator trim code that switches between two fixed settings, one slow and one fast, inside a repeating frame. Averaged over time, the oscillator frequency lands between the slow point and the fast point. The share of the frame spent at each point sets where the average falls.

A companion toggle timer sends a one-cycle strobe on each of its half-cycle overflows. The block counts these strobes. The count wraps after `FRAME` events, 1000 by default. While the count is below an active threshold, the block drives the slow code. From the threshold to the end of the frame, it drives the fast code.

A control loop steers the threshold in one of two ways:
- It writes the threshold directly.
- It sends slow-down and speed-up strobes that move the threshold by one step.

Every change goes into a pending register first. The pending value becomes active only at a frame boundary, so the duty of a frame never changes partway through it.

Top module: `trim_dither`

## Requirements
- R1: Each cycle with `half_evt` high advances the frame count by one. Cycles without it leave the count unchanged.
- R2: An event that arrives while the count is `FRAME-1` returns the count to 0, so one frame is `FRAME` events long.
- R3: While the count is below the active threshold, `trim_code` is the slow code 4'b0010.
- R4: While the count is at or above the active threshold, `trim_code` is the fast code 4'b1100.
- R5: `thr_set` loads `thr_val` into the pending threshold. A value above `FRAME` is stored as `FRAME`.
- R6: `thr_up` raises the pending threshold by one and stops at `FRAME`. `thr_dn` lowers it by one and stops at 0. When both are high together, the pending threshold does not change. `thr_set` takes priority over both strobes.
- R7: The active threshold takes the pending value only on the event that wraps the count. A change made in the middle of a frame does not alter the output until the next frame.
- R8: After reset, the count is 0 and both thresholds hold `THR_DEFAULT` (500 by default). With a nonzero default, the output is therefore the slow code.
- R9: An active threshold of 0 gives the fast code for the whole frame. An active threshold of `FRAME` gives the slow code for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_evt | input | 1 | Half-cycle overflow strobe from the toggle timer |
| thr_set | input | 1 | Load strobe for `thr_val` |
| thr_val | input | $clog2(FRAME+1) | New threshold value |
| thr_up | input | 1 | Slow-down request: raises the threshold by one |
| thr_dn | input | 1 | Speed-up request: lowers the threshold by one |
| trim_code | output | 4 | Oscillator trim code |

## Verification
The bench uses a frame of 20 events. It sweeps every writable threshold value, 0 through 31. This separates the in-range cases from the clamped values, and it shows the two edge cases where the whole frame is fast or the whole frame is slow.

Each write lands in the middle of a frame, with the output checked after every event. This separates a correct design, which changes at the next frame boundary, from one that applies the change at once.

Further runs cover:
- step requests pushed past both limits;
- both step strobes raised together;
- `thr_set` raised at the same time as a step strobe;
- idle cycles placed between events, which check that the count holds without an event.

// File: rtl/trim_dither.sv
module trim_dither #(
  parameter int FRAME       = 1000,
  parameter int THR_DEFAULT = 500,
  parameter logic [3:0] SLOW_CODE = 4'b0010,
  parameter logic [3:0] FAST_CODE = 4'b1100,
  localparam int CW = $clog2(FRAME + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          half_evt,
  input  logic          thr_set,
  input  logic [CW-1:0] thr_val,
  input  logic          thr_up,
  input  logic          thr_dn,
  output logic [3:0]    trim_code
);
  localparam logic [CW-1:0] LAST = CW'(FRAME - 1);
  localparam logic [CW-1:0] TOP  = CW'(FRAME);

  logic [CW-1:0] cnt, thr_pend, thr_act;
  logic          wrap;

  assign wrap      = half_evt && (cnt == LAST);
  assign trim_code = (cnt < thr_act) ? SLOW_CODE : FAST_CODE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      thr_pend <= CW'(THR_DEFAULT);
      thr_act  <= CW'(THR_DEFAULT);
    end else begin
      if (half_evt) cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) thr_act <= thr_pend;
      if (thr_set)
        thr_pend <= (thr_val > TOP) ? TOP : thr_val;
      else if (thr_up && !thr_dn && thr_pend != TOP)
        thr_pend <= thr_pend + 1'b1;
      else if (thr_dn && !thr_up && thr_pend != '0)
        thr_pend <= thr_pend - 1'b1;
    end
  end
endmodule

module trim_dither_chk #(
  parameter int FRAME = 1000,
  parameter logic [3:0] SLOW_CODE = 4'b0010,
  parameter logic [3:0] FAST_CODE = 4'b1100,
  localparam int CW = $clog2(FRAME + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          half_evt,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] thr_pend,
  input logic [CW-1:0] thr_act,
  input logic [3:0]    trim_code
);
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(FRAME)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    half_evt && cnt == CW'(FRAME - 1) |=> cnt == '0); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !half_evt |=> $stable(cnt)); // R1
  AST_ACT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !(half_evt && cnt == CW'(FRAME - 1)) |=> $stable(thr_act)); // R7
  AST_PEND_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    thr_pend <= CW'(FRAME)); // R5
  AST_TWO_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    trim_code == SLOW_CODE || trim_code == FAST_CODE); // R3
endmodule

bind trim_dither trim_dither_chk #(.FRAME(FRAME), .SLOW_CODE(SLOW_CODE), .FAST_CODE(FAST_CODE))
  u_chk (.clk(clk), .rst_n(rst_n), .half_evt(half_evt), .cnt(cnt),
         .thr_pend(thr_pend), .thr_act(thr_act), .trim_code(trim_code));

// File: tb/sim_trim_dither.sv
`timescale 1ns/1ps
module sim_trim_dither;
  localparam int FRAME = 20;
  localparam int DEF   = 10;
  localparam int CW    = $clog2(FRAME + 1);
  localparam logic [3:0] SLOW = 4'b0010;
  localparam logic [3:0] FAST = 4'b1100;

  logic clk = 0, rst_n = 0, half_evt = 0, thr_set = 0, thr_up = 0, thr_dn = 0;
  logic [CW-1:0] thr_val = '0;
  logic [3:0] trim_code;
  int checks = 0, fails = 0;
  int m_cnt, m_pend, m_act;

  always #2.5 clk = ~clk;

  trim_dither #(.FRAME(FRAME), .THR_DEFAULT(DEF)) u0 (
    .clk(clk), .rst_n(rst_n), .half_evt(half_evt), .thr_set(thr_set),
    .thr_val(thr_val), .thr_up(thr_up), .thr_dn(thr_dn), .trim_code(trim_code));

  task automatic check(input string tag);
    logic [3:0] exp;
    exp = (m_cnt < m_act) ? SLOW : FAST;
    checks++;
    if (trim_code !== exp) begin
      fails++;
      $display("FAIL %s cnt=%0d thr=%0d actual=%b expected=%b", tag, m_cnt, m_act, trim_code, exp);
    end
  endtask

  task automatic tick(input logic e, input logic s, input int v, input logic u, input logic d, input string tag);
    int n_cnt, n_pend, n_act;
    half_evt = e; thr_set = s; thr_val = CW'(v); thr_up = u; thr_dn = d;
    @(posedge clk); #1;
    half_evt = 0; thr_set = 0; thr_up = 0; thr_dn = 0;
    n_cnt = m_cnt; n_act = m_act; n_pend = m_pend;
    if (e) begin
      n_cnt = (m_cnt == FRAME - 1) ? 0 : m_cnt + 1;
      if (m_cnt == FRAME - 1) n_act = m_pend;
    end
    if (s) n_pend = (v > FRAME) ? FRAME : v;
    else if (u && !d && m_pend < FRAME) n_pend = m_pend + 1;
    else if (d && !u && m_pend > 0) n_pend = m_pend - 1;
    m_cnt = n_cnt; m_pend = n_pend; m_act = n_act;
    check(tag);
  endtask

  task automatic frames(input int n, input string tag);
    for (int i = 0; i < n * FRAME; i++) tick(1, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_cnt = 0; m_pend = DEF; m_act = DEF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R8 reset slow code");
    frames(2, "R3 R4 default frame");
    for (int i = 0; i < 5; i++) begin
      tick(0, 0, 0, 0, 0, "R1 idle hold");
      tick(1, 0, 0, 0, 0, "R1 advance");
    end
    for (int t = 0; t < (1 << CW); t++) begin
      while (m_cnt != FRAME / 2) tick(1, 0, 0, 0, 0, "R2 align");
      tick(1, 1, t, 0, 0, "R5 R7 load mid-frame");
      frames(1, "R7 old threshold then new");
      frames(1, "R9 R3 R4 threshold sweep");
    end
    tick(1, 1, FRAME - 1, 0, 0, "R5 load");
    for (int i = 0; i < 3; i++) tick(1, 0, 0, 1, 0, "R6 up saturate");
    frames(2, "R9 all slow");
    tick(1, 1, 1, 0, 0, "R5 load");
    for (int i = 0; i < 3; i++) tick(1, 0, 0, 0, 1, "R6 down saturate");
    frames(2, "R9 all fast");
    tick(1, 1, 7, 0, 0, "R5 load");
    tick(1, 0, 0, 1, 1, "R6 both no change");
    tick(1, 1, 12, 1, 0, "R6 set priority");
    frames(2, "R6 R7 result");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule